// File: doc/BRIEF.md
# Linear Chirp Sine Generator

This block produces a stream of signed sine samples whose frequency rises (or falls, through wrap-around) linearly in time. It is meant to drive a DAC directly. A start pulse loads a start frequency word into a frequency register. Every sample clock, that register is added into a phase register. At a slower, programmable tick rate, a sweep step is added to the frequency register. The upper phase bits address a table that holds one quarter of a sine wave, and the quadrant logic rebuilds the full cycle from it.

The sweep lasts a programmed number of frequency ticks. While it runs, `busy` is high. The samples appear two cycles after the phase that produced them, and `sample_valid` marks them. Once the sweep is over the output rests at zero until the next start pulse.

Top module: `chirp_dds`

## Requirements
- R1: While `rst_n` is low, `busy` and `sample_valid` are 0 and `sample` is 0.
- R2: A `start` pulse seen while idle does the following at that clock edge: it sets the frequency register to `start_freq`, clears the phase register, captures `sweep_step`, `step_div` and `chirp_len`, and raises `busy`.
- R3: While busy, the frequency register changes only on a tick. A tick happens every `step_div`+1 cycles, the first one `step_div`+1 cycles after start. On each tick the captured step is added to the frequency register modulo 2^32.
- R4: On every busy cycle, the phase register adds the current frequency word modulo 2^32. While idle the phase register holds its value.
- R5: The sample for phase p is built from three fields of p. Bits 31:30 give the quadrant q, and bits 29:20 give the index a. For odd q the index is inverted bitwise (1023-a). The magnitude at index k is round(2047·sin(π/2·(k+0.5)/1024)). The sample is negated when q ≥ 2.
- R6: The sample for the phase held during busy cycle n (n=0 is the start edge) appears with `sample_valid` high two clock edges later. `sample_valid` is high for exactly `chirp_len`·(`step_div`+1) consecutive cycles.
- R7: `busy` falls on the `chirp_len`-th tick. Once the pipeline drains, `sample_valid` is 0 and `sample` is 0.
- R8: While busy, the following have no effect on the sweep or on any output: `start`, and any change of `start_freq`, `sweep_step`, `step_div` or `chirp_len`.
- R9: A start pulse after a sweep has ended repeats the sweep from the start frequency with phase zero. The same settings give the same sample sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (honoured only when idle) |
| start_freq | input | 32 | Initial phase increment |
| sweep_step | input | 32 | Increment added to the frequency word per tick |
| step_div | input | 16 | Cycles between ticks, minus one |
| chirp_len | input | 16 | Number of ticks in a sweep |
| sample | output | 12 | Signed sine amplitude |
| sample_valid | output | 1 | Sample carries a sweep value |
| busy | output | 1 | Sweep in progress |

## Verification
A wrong frequency word shows up at the ports as a phase error, and that error keeps growing. If the frequency register were loaded or stepped wrongly, the sample sequence would leave the expected one within a few samples of the first wrong tick. A wrong phase register or wrong quadrant handling corrupts the very next valid sample, two edges later. The bench compares every valid sample against a reference sweep, so a wrong value is caught on the cycle it appears. Errors in the tick counters or the length counter show up as a wrong edge of `busy` or of `sample_valid`, and the bench checks both on every cycle.

// File: rtl/chirp_dds.sv
`timescale 1ns/1ps
module chirp_dds #(
  parameter int FW   = 32,
  parameter int PW   = 32,
  parameter int AW   = 10,
  parameter int DW   = 12,
  parameter int DIVW = 16,
  parameter int LENW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FW-1:0]        start_freq,
  input  logic [FW-1:0]        sweep_step,
  input  logic [DIVW-1:0]      step_div,
  input  logic [LENW-1:0]      chirp_len,
  output logic signed [DW-1:0] sample,
  output logic                 sample_valid,
  output logic                 busy
);
  localparam int    TSZ = 1 << AW;
  localparam int    AMP = (1 << (DW-1)) - 1;
  localparam real   HALF_PI = 1.5707963267948966;

  logic [DW-2:0] qtab [TSZ];
  initial begin
    for (int i = 0; i < TSZ; i++)
      qtab[i] = (DW-1)'($rtoi(real'(AMP) * $sin(HALF_PI * (real'(i) + 0.5) / real'(TSZ)) + 0.5));
  end

  logic [FW-1:0]   freq, step_l;
  logic [PW-1:0]   phase;
  logic [DIVW-1:0] div_l, div_cnt;
  logic [LENW-1:0] len_l, step_cnt;
  logic            tick, last;

  assign tick = busy && (div_cnt == div_l);
  assign last = tick && (step_cnt == len_l - LENW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      freq     <= '0;
      phase    <= '0;
      step_l   <= '0;
      div_l    <= '0;
      len_l    <= '0;
      div_cnt  <= '0;
      step_cnt <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        freq     <= start_freq;
        phase    <= '0;
        step_l   <= sweep_step;
        div_l    <= step_div;
        len_l    <= chirp_len;
        div_cnt  <= '0;
        step_cnt <= '0;
      end
    end else begin
      phase <= phase + PW'(freq);
      if (tick) begin
        div_cnt  <= '0;
        freq     <= freq + step_l;
        step_cnt <= step_cnt + LENW'(1);
        if (last) busy <= 1'b0;
      end else begin
        div_cnt <= div_cnt + DIVW'(1);
      end
    end
  end

  logic [1:0]    quad;
  logic [AW-1:0] raw_idx, idx;
  logic [DW-2:0] mag_q;
  logic          neg_q, v_q;

  assign quad    = phase[PW-1 -: 2];
  assign raw_idx = phase[PW-3 -: AW];
  assign idx     = quad[0] ? ~raw_idx : raw_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q        <= '0;
      neg_q        <= 1'b0;
      v_q          <= 1'b0;
      sample_valid <= 1'b0;
      sample       <= '0;
    end else begin
      mag_q        <= qtab[idx];
      neg_q        <= quad[1];
      v_q          <= busy;
      sample_valid <= v_q;
      if (!v_q)       sample <= '0;
      else if (neg_q) sample <= -$signed({1'b0, mag_q});
      else            sample <= $signed({1'b0, mag_q});
    end
  end
endmodule

// File: rtl/chirp_dds_chk.sv
`timescale 1ns/1ps
module chirp_dds_chk #(
  parameter int FW = 32,
  parameter int PW = 32,
  parameter int DW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [FW-1:0]        start_freq,
  input logic                 start,
  input logic                 busy,
  input logic                 tick,
  input logic [FW-1:0]        freq,
  input logic [PW-1:0]        phase,
  input logic                 sample_valid,
  input logic signed [DW-1:0] sample
);
  localparam int AMP = (1 << (DW-1)) - 1;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (phase == '0 && freq == $past(start_freq)));

  p_freq_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(freq));

  p_phase_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(phase));

  p_amp_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (sample <= AMP && sample >= -AMP));

  p_valid_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(busy, 2));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> (sample == '0));
endmodule

bind chirp_dds chirp_dds_chk #(.FW(FW), .PW(PW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_freq(start_freq), .start(start),
  .busy(busy), .tick(tick), .freq(freq), .phase(phase),
  .sample_valid(sample_valid), .sample(sample)
);

// File: tb/chirp_dds_bench.sv
`timescale 1ns/1ps
module chirp_dds_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_freq = '0, sweep_step = '0;
  logic [15:0] step_div = '0, chirp_len = '0;
  logic signed [11:0] sample;
  logic        sample_valid, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chirp_dds u_chirp_dds (
    .clk(clk), .rst_n(rst_n), .start(start), .start_freq(start_freq),
    .sweep_step(sweep_step), .step_div(step_div), .chirp_len(chirp_len),
    .sample(sample), .sample_valid(sample_valid), .busy(busy)
  );

  function automatic int exp_amp(logic [31:0] ph);
    int a, m;
    a = int'(ph[29:20]);
    if (ph[30]) a = 1023 - a;
    m = $rtoi(2047.0 * $sin(1.5707963267948966 * (real'(a) + 0.5) / 1024.0) + 0.5);
    return ph[31] ? -m : m;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_chirp(logic [31:0] f0, logic [31:0] st, int dv, int ln, int inj, string req);
    int total, n;
    logic [31:0] ph, f;
    @(negedge clk);
    start = 1'b1; start_freq = f0; sweep_step = st;
    step_div = 16'(dv); chirp_len = 16'(ln);
    @(negedge clk);
    start = 1'b0;
    total = ln * (dv + 1);
    ph = '0; f = f0; n = 0;
    for (int i = 0; i < total + 4; i++) begin
      if (i == inj) begin
        start = 1'b1; start_freq = $urandom; sweep_step = $urandom;
        step_div = 16'($urandom % 3); chirp_len = 16'(1 + $urandom % 3);
      end else if (i == inj + 1) begin
        start = 1'b0;
      end
      chk(busy == (i < total), (inj >= 0) ? "R8 busy" : "R7 busy", int'(busy), int'(i < total));
      if (i >= 2 && i - 2 < total) begin
        chk(sample_valid == 1'b1, "R6 valid", int'(sample_valid), 1);
        chk(int'(sample) == exp_amp(ph), req, int'(sample), exp_amp(ph));
        ph = ph + f;
        if (n % (dv + 1) == dv) f = f + st;
        n++;
      end else begin
        chk(sample_valid == 1'b0, "R6 idle valid", int'(sample_valid), 0);
        chk(sample == '0, "R7 idle sample", int'(sample), 0);
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(sample_valid == 1'b0, "R1 valid", int'(sample_valid), 0);
    chk(sample == '0, "R1 sample", int'(sample), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 quadrant boundaries: phase 0, 1/4, 1/2, 3/4 turn
    run_chirp(32'h4000_0000, 32'h0, 0, 8, -1, "R5 quadrants");
    // R6 shortest sweep
    run_chirp(32'h0123_4567, 32'h0000_1000, 0, 1, -1, "R6 minimum sweep");
    // R3 frequency word wraps past 2^32
    run_chirp(32'hFFFF_F000, 32'h0000_2000, 2, 6, -1, "R3 freq wrap");
    // R4 phase wraps quickly with large increment
    run_chirp(32'hC000_0001, 32'h0100_0000, 1, 5, -1, "R4 phase wrap");
    // R2 loaded start value sets first increment
    run_chirp(32'h0800_0000, 32'h0010_0000, 3, 4, -1, "R2 start load");
    // R8 start and settings changed mid-sweep
    run_chirp(32'h0200_0000, 32'h0004_0000, 2, 8, 7, "R8 start ignored");
    // R9 restart after previous sweep left phase nonzero
    run_chirp(32'h0200_0000, 32'h0004_0000, 2, 8, -1, "R9 restart");

    for (int k = 0; k < 25; k++) begin
      int dv, ln, inj;
      dv  = int'($urandom % 4);
      ln  = 1 + int'($urandom % 12);
      inj = ($urandom % 2 == 0) ? -1 : int'($urandom % (ln * (dv + 1)));
      run_chirp($urandom, $urandom, dv, ln, inj, "R5 random sweep");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule